// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the fetch program counter and decides, in the same cycle, which address the fetch unit should request next. It keeps a small direct-mapped table of branch entries. Each entry holds a valid flag, an address tag, a stored target and a single direction bit. The lookup presents the fetch PC and gets back the next fetch PC, a hit flag and a taken flag. A miss, or a hit whose direction bit is clear, yields the sequential address (PC + 4). A hit whose direction bit is set yields the stored target.

The table learns only from committed branches. The commit stage presents the branch PC, its actual direction, its actual target and a flag saying the fetch-time guess was wrong. A missed lookup counts as a wrong guess. Only updates carrying that flag write the table. Both taken and not-taken outcomes are recorded. The indexed slot is simply overwritten: nothing is chosen for replacement, so an entry for another branch that maps to the same slot is lost.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until the first accepted update.
- R2: The slot is selected by PC bits [4:2]. The tag is PC bits [31:5]. A hit needs the slot valid and its tag equal to the fetch PC's tag, so a PC with a different slot does not hit.
- R3: On a hit whose direction bit is 1, `pred_hit`=1, `pred_taken`=1, and `next_pc` equals the stored target in the same cycle.
- R4: On a hit whose direction bit is 0, `pred_hit`=1, `pred_taken`=0, and `next_pc` is `fetch_pc`+4.
- R5: On a miss, `pred_hit`=0, `pred_taken`=0, and `next_pc` is `fetch_pc`+4.
- R6: An update with `upd_valid`=1 and `upd_mispredict`=1 writes the slot at the clock edge. A lookup of that PC in the next cycle hits and returns the written direction and target.
- R7: An update with `upd_valid`=0, or with `upd_mispredict`=0, leaves the table unchanged.
- R8: An accepted update to a PC already present overwrites its direction, in either direction.
- R9: An accepted update for a PC whose slot holds a different tag replaces that slot, so the former branch then misses.
- R10: When a lookup and an accepted update use the same slot in the same cycle, the lookup returns the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched |
| next_pc | output | 32 | Predicted next fetch address |
| pred_hit | output | 1 | Lookup found a matching valid entry |
| pred_taken | output | 1 | Lookup predicts taken |
| upd_valid | input | 1 | A branch is committing this cycle |
| upd_pc | input | 32 | Address of the committing branch |
| upd_taken | input | 1 | Actual direction of the branch |
| upd_target | input | 32 | Actual taken target of the branch |
| upd_mispredict | input | 1 | Fetch-time guess was a miss or wrong |

## Verification
The lookup outputs are combinational: `next_pc`, `pred_hit` and `pred_taken` follow `fetch_pc` within the same cycle. The bench therefore drives `fetch_pc` on the falling edge and samples 1 ns later, before the next rising edge. An update lands on the first rising edge after it is presented. Its effect is checked with a lookup made after that edge and before the following one. The collision case is checked twice. The first sample is taken before the edge that writes the slot and must show the old contents. The second is taken after that edge and must show the new contents.

// File: rtl/btb_pkg.sv
package btb_pkg;

   // per-slot status bits kept apart from tag/target storage
   typedef struct packed {
      logic valid;
      logic taken;
   } btb_flags_t;

   localparam btb_flags_t BTB_FLAGS_CLEAR = '{valid: 1'b0, taken: 1'b0};

endpackage

// File: rtl/btb_store.sv
module btb_store
   import btb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3,
   parameter int TAG_W   = 27,
   parameter int ADDR_W  = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [TAG_W-1:0]                  wr_tag,
   input  logic [ADDR_W-1:0]                 wr_target,
   input  logic                              wr_taken,
   output btb_flags_t [ENTRIES-1:0]          flags_o,
   output logic [ENTRIES-1:0][TAG_W-1:0]     tags_o,
   output logic [ENTRIES-1:0][ADDR_W-1:0]    targets_o
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic hit_wr;
      assign hit_wr = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags_o[e]   <= BTB_FLAGS_CLEAR;
            tags_o[e]    <= '0;
            targets_o[e] <= '0;
         end else if (hit_wr) begin
            flags_o[e]   <= '{valid: 1'b1, taken: wr_taken};
            tags_o[e]    <= wr_tag;
            targets_o[e] <= wr_target;
         end
      end
   end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
   import btb_pkg::*;
#(
   parameter int ENTRIES    = 8,
   parameter int IDX_W      = 3,
   parameter int TAG_W      = 27,
   parameter int ADDR_W     = 32,
   parameter bit ONEHOT_SEL = 1'b0
) (
   input  logic [IDX_W-1:0]               rd_idx,
   input  logic [TAG_W-1:0]               rd_tag,
   input  logic [ADDR_W-1:0]              seq_pc,
   input  btb_flags_t [ENTRIES-1:0]       flags_i,
   input  logic [ENTRIES-1:0][TAG_W-1:0]  tags_i,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] targets_i,
   output logic                           hit_o,
   output logic                           taken_o,
   output logic [ADDR_W-1:0]              next_o
);

   btb_flags_t         sel_flags;
   logic [TAG_W-1:0]   sel_tag;
   logic [ADDR_W-1:0]  sel_target;

   if (ONEHOT_SEL) begin : g_onehot
      logic [ENTRIES-1:0] dec;
      always_comb begin
         sel_flags  = BTB_FLAGS_CLEAR;
         sel_tag    = '0;
         sel_target = '0;
         for (int e = 0; e < ENTRIES; e++) begin
            dec[e]     = (rd_idx == IDX_W'(e));
            sel_flags  = sel_flags  | (flags_i[e]   & {2{dec[e]}});
            sel_tag    = sel_tag    | (tags_i[e]    & {TAG_W{dec[e]}});
            sel_target = sel_target | (targets_i[e] & {ADDR_W{dec[e]}});
         end
      end
   end else begin : g_mux
      always_comb begin
         sel_flags  = flags_i[rd_idx];
         sel_tag    = tags_i[rd_idx];
         sel_target = targets_i[rd_idx];
      end
   end

   always_comb begin
      hit_o   = sel_flags.valid && (sel_tag == rd_tag);
      taken_o = hit_o && sel_flags.taken;
      next_o  = taken_o ? sel_target : seq_pc;
   end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
   import btb_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int ENTRIES     = 8,
   parameter int INSTR_BYTES = 4,
   parameter bit ONEHOT_SEL  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] next_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_mispredict
);

   localparam int OFS_W   = $clog2(INSTR_BYTES);
   localparam int IDX_W   = $clog2(ENTRIES);
   localparam int TAG_LSB = OFS_W + IDX_W;
   localparam int TAG_W   = PC_W - TAG_LSB;

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("btb_predictor: ENTRIES must be a power of two, at least 2");
   end
   if (INSTR_BYTES < 1 || (INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_bad_step
      $error("btb_predictor: INSTR_BYTES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_width
      $error("btb_predictor: PC_W too narrow for index and offset");
   end

   btb_flags_t [ENTRIES-1:0]       flags;
   logic [ENTRIES-1:0][TAG_W-1:0]  tags;
   logic [ENTRIES-1:0][PC_W-1:0]   targets;

   logic [PC_W-1:0] upd_seq;
   logic [PC_W-1:0] wr_target;
   logic            wr_en;

   assign upd_seq   = upd_pc + PC_W'(INSTR_BYTES);
   assign wr_en     = upd_valid && upd_mispredict;
   assign wr_target = upd_taken ? upd_target : upd_seq;

   btb_store #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W),
      .TAG_W   (TAG_W),
      .ADDR_W  (PC_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (upd_pc[OFS_W +: IDX_W]),
      .wr_tag    (upd_pc[PC_W-1:TAG_LSB]),
      .wr_target (wr_target),
      .wr_taken  (upd_taken),
      .flags_o   (flags),
      .tags_o    (tags),
      .targets_o (targets)
   );

   btb_lookup #(
      .ENTRIES    (ENTRIES),
      .IDX_W      (IDX_W),
      .TAG_W      (TAG_W),
      .ADDR_W     (PC_W),
      .ONEHOT_SEL (ONEHOT_SEL)
   ) u_lookup (
      .rd_idx    (fetch_pc[OFS_W +: IDX_W]),
      .rd_tag    (fetch_pc[PC_W-1:TAG_LSB]),
      .seq_pc    (fetch_pc + PC_W'(INSTR_BYTES)),
      .flags_i   (flags),
      .tags_i    (tags),
      .targets_i (targets),
      .hit_o     (pred_hit),
      .taken_o   (pred_taken),
      .next_o    (next_pc)
   );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
   parameter int PC_W        = 32,
   parameter int ENTRIES     = 8,
   parameter int INSTR_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [PC_W-1:0] next_pc,
   input logic            pred_hit,
   input logic            pred_taken,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken,
   input logic            upd_mispredict
);

   localparam int OFS_W   = $clog2(INSTR_BYTES);
   localparam int IDX_W   = $clog2(ENTRIES);
   localparam int TAG_LSB = OFS_W + IDX_W;

   logic fire;
   assign fire = upd_valid && upd_mispredict;

   // R5
   miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (!pred_taken && next_pc == fetch_pc + PC_W'(INSTR_BYTES)));

   // R4
   hit_nt_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_hit && !pred_taken) |-> (next_pc == fetch_pc + PC_W'(INSTR_BYTES)));

   // R6
   learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fire) && fetch_pc == $past(upd_pc))
      |-> (pred_hit && pred_taken == $past(upd_taken)));

   // R9
   evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fire)
       && fetch_pc[OFS_W +: IDX_W] == $past(upd_pc[OFS_W +: IDX_W])
       && fetch_pc[PC_W-1:TAG_LSB] != $past(upd_pc[PC_W-1:TAG_LSB]))
      |-> !pred_hit);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(fire) && $stable(fetch_pc))
      |-> ($stable(next_pc) && $stable(pred_hit) && $stable(pred_taken)));

endmodule

bind btb_predictor btb_predictor_chk #(
   .PC_W        (PC_W),
   .ENTRIES     (ENTRIES),
   .INSTR_BYTES (INSTR_BYTES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fetch_pc       (fetch_pc),
   .next_pc        (next_pc),
   .pred_hit       (pred_hit),
   .pred_taken     (pred_taken),
   .upd_valid      (upd_valid),
   .upd_pc         (upd_pc),
   .upd_taken      (upd_taken),
   .upd_mispredict (upd_mispredict)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] fetch_pc;
   logic [31:0] next_pc;
   logic        pred_hit;
   logic        pred_taken;
   logic        upd_valid;
   logic [31:0] upd_pc;
   logic        upd_taken;
   logic [31:0] upd_target;
   logic        upd_mispredict;

   int n_vec  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   btb_predictor dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .fetch_pc       (fetch_pc),
      .next_pc        (next_pc),
      .pred_hit       (pred_hit),
      .pred_taken     (pred_taken),
      .upd_valid      (upd_valid),
      .upd_pc         (upd_pc),
      .upd_taken      (upd_taken),
      .upd_target     (upd_target),
      .upd_mispredict (upd_mispredict)
   );

   // lookup is combinational: set pc now, sample 1 ns later
   task automatic look(input logic [31:0] pc, input logic eh, input logic et,
                       input logic [31:0] en, input string req);
      fetch_pc = pc;
      #1;
      n_vec++;
      if (pred_hit !== eh || pred_taken !== et || next_pc !== en) begin
         n_fail++;
         $display("FAIL %s pc=%h: got hit=%b taken=%b next=%h, want hit=%b taken=%b next=%h",
                  req, pc, pred_hit, pred_taken, next_pc, eh, et, en);
      end
   endtask

   // present an update for exactly one rising edge
   task automatic commit(input logic v, input logic [31:0] pc, input logic tk,
                         input logic [31:0] tg, input logic mp);
      @(negedge clk);
      upd_valid = v; upd_pc = pc; upd_taken = tk; upd_target = tg; upd_mispredict = mp;
      @(negedge clk);
      upd_valid = 1'b0; upd_mispredict = 1'b0;
   endtask

   task automatic t_reset();
      look(32'h0000_0000, 1'b0, 1'b0, 32'h0000_0004, "R1");
      look(32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104, "R1");
      look(32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0000_0000, "R5");
   endtask

   task automatic t_taken();
      commit(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0400, 1'b1);
      look(32'h0000_0100, 1'b1, 1'b1, 32'h0000_0400, "R6 R3");
      // index 1 differs, still empty
      look(32'h0000_0104, 1'b0, 1'b0, 32'h0000_0108, "R2");
      look(32'h0000_0200, 1'b0, 1'b0, 32'h0000_0204, "R2");
   endtask

   task automatic t_flip();
      commit(1'b1, 32'h0000_0100, 1'b0, 32'h0000_0999, 1'b1);
      look(32'h0000_0100, 1'b1, 1'b0, 32'h0000_0104, "R8 R4");
      commit(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0440, 1'b1);
      look(32'h0000_0100, 1'b1, 1'b1, 32'h0000_0440, "R8 R3");
   endtask

   task automatic t_ignore();
      commit(1'b1, 32'h0000_0100, 1'b0, 32'h0000_0000, 1'b0);
      look(32'h0000_0100, 1'b1, 1'b1, 32'h0000_0440, "R7");
      commit(1'b0, 32'h0000_0100, 1'b0, 32'h0000_0000, 1'b1);
      look(32'h0000_0100, 1'b1, 1'b1, 32'h0000_0440, "R7");
   endtask

   task automatic t_alias();
      commit(1'b1, 32'h0000_0120, 1'b1, 32'h0000_0800, 1'b1);
      look(32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104, "R9");
      look(32'h0000_0120, 1'b1, 1'b1, 32'h0000_0800, "R9 R2");
   endtask

   task automatic t_collide();
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = 32'h0000_0120; upd_taken = 1'b0;
      upd_target = 32'h0; upd_mispredict = 1'b1;
      look(32'h0000_0120, 1'b1, 1'b1, 32'h0000_0800, "R10");
      @(negedge clk);
      upd_valid = 1'b0; upd_mispredict = 1'b0;
      look(32'h0000_0120, 1'b1, 1'b0, 32'h0000_0124, "R10");
   endtask

   initial begin
      rst_n = 1'b0; fetch_pc = '0;
      upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_target = '0; upd_mispredict = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_taken();
      t_flip();
      t_ignore();
      t_alias();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #20000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout, want finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule